// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block feeds an outgoing byte stream from buffers that software places in memory. Software builds a ring of descriptors. Each descriptor is two 32-bit words: a control word, then a word-aligned buffer address. Software hands a descriptor to the engine by setting its ownership bit. The engine reads the descriptor and fetches the buffer one word at a time. It emits the buffer as bytes on a valid/ready stream, marked with packet start, packet end and a request to append a frame check sequence.

Once the last byte of a buffer has been accepted downstream, the engine writes the control word back with ownership cleared. It then raises status bits and moves to the next slot. A descriptor whose ownership bit is clear parks the engine. It stays parked until software writes the enable bit again, and it then resumes at that same slot.

Registers are word-indexed on a 3-bit address:
- 0: control. Bit 0 is the enable; bit 1 reads back as the active flag.
- 1: status, write-one-to-clear.
- 2: interrupt mask.
- 3: maximum burst, counted in 64-bit words.
- 4: ring base.

Top module: `txring_dma`

## Requirements
- R1: After reset, tx_valid, irq and mem_req are low; register 0 reads 0 and register 3 reads 8.
- R2: A descriptor at ring offset n holds its control word at n and its buffer address at n+4. The control word carries the byte length in bits 27:16 and ownership in bit 15. Only a descriptor with bit 15 set is transmitted. Its bytes leave in little-endian order, lowest address first.
- R3: After the final byte of a buffer is accepted, the control word in memory is rewritten with bit 15 cleared and every other bit unchanged.
- R4: tx_sop marks the first byte of a buffer whose bit 13 is set. tx_last marks only the final byte of a buffer whose bit 14 is set. tx_crc marks only that first byte, and only when both bit 13 and bit 8 are set.
- R5: The next descriptor is read 8 bytes further on. After a descriptor with bit 12 set, the next one is read at the ring base.
- R6: Register 4 keeps only bits 31:6 of a written value; bits 5:0 read back as zero.
- R7: A descriptor with bit 15 clear does three things: it sets status bit 2, it clears the active flag, and it stops all memory requests and stream output. This lasts until register 0 is written with bit 0 set, after which the engine re-reads that same descriptor.
- R8: Writing 0 to register 0 lets the current buffer finish and write back. The engine then stops without reading the next descriptor.
- R9: Consecutive accesses made while mem_req stays high number at most twice the value of register 3, where a value of 0 counts as 1. A long buffer reaches that limit.
- R10: Status bit 0 sets when a buffer is written back. Bit 1 also sets when that buffer had bit 14 set. Writing 1 to a status bit clears it.
- R11: irq is high exactly when status ANDed with register 2 is nonzero, one cycle after the status change.
- R12: While tx_valid is high and tx_ready is low, tx_data, tx_sop, tx_last and tx_crc hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_re |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access done; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_last | output | 1 | Final byte of a packet |
| tx_crc | output | 1 | Append-check-sequence request, on the first byte |
| irq | output | 1 | Masked interrupt |

## Verification
Two functions can land in the same cycle. Buffer data words are fetched ahead into a small queue while the byte stream drains it under back-pressure, so a queue push and a pop can coincide. The burst limit and the queue-room limit can also end a request run on the same access. The bench provokes both by setting a small burst value and stalling tx_ready on a repeating pattern during a 40-byte buffer. A scoreboard then judges every emitted byte against the expected sequence. A model of the memory measures the longest unbroken request run, which must equal twice the burst value.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int CTL_OWN  = 15;
  localparam int CTL_EOP  = 14;
  localparam int CTL_SOP  = 13;
  localparam int CTL_WRAP = 12;
  localparam int CTL_CRC  = 8;
  localparam int LEN_LO   = 16;
  localparam int LEN_W    = 12;

  localparam logic [2:0] RG_CTRL  = 3'd0;
  localparam logic [2:0] RG_STAT  = 3'd1;
  localparam logic [2:0] RG_MASK  = 3'd2;
  localparam logic [2:0] RG_BURST = 3'd3;
  localparam logic [2:0] RG_BASE  = 3'd4;

  typedef struct packed {
    logic [31:0] data;
    logic [2:0]  nb;
    logic        first;
    logic        last;
    logic        crc;
  } beat_word_t;

  typedef enum logic [3:0] {
    E_IDLE, E_CTL, E_EVAL, E_ADR, E_DATA, E_DRAIN, E_WB, E_NEXT
  } eng_st_t;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int BURST_W   = 6,
  parameter int BURST_RST = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic               re,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic               active,
  input  logic               set_bdone,
  input  logic               set_pdone,
  input  logic               set_nodesc,
  output logic               enable,
  output logic               kick,
  output logic               base_wr,
  output logic [31:0]        base_new,
  output logic [31:0]        base,
  output logic [BURST_W-1:0] burst,
  output logic               irq
);
  logic [2:0]  stat, mask, clr, setv;
  logic [25:0] base_hi;

  assign kick     = we && addr == RG_CTRL && wdata[0];
  assign base_wr  = we && addr == RG_BASE;
  assign base_new = {wdata[31:6], 6'b0};
  assign base     = {base_hi, 6'b0};
  assign clr      = (we && addr == RG_STAT) ? wdata[2:0] : 3'b0;
  assign setv     = {set_nodesc, set_pdone, set_bdone};

  always_ff @(posedge clk) begin
    if (rst) begin
      enable  <= 1'b0;
      stat    <= '0;
      mask    <= '0;
      burst   <= BURST_W'(BURST_RST);
      base_hi <= '0;
      rdata   <= '0;
      irq     <= 1'b0;
    end else begin
      stat <= (stat & ~clr) | setv;
      irq  <= |(stat & mask);
      if (we) begin
        case (addr)
          RG_CTRL:  enable  <= wdata[0];
          RG_MASK:  mask    <= wdata[2:0];
          RG_BURST: burst   <= wdata[BURST_W-1:0];
          RG_BASE:  base_hi <= wdata[31:6];
          default:  ;
        endcase
      end
      if (re) begin
        case (addr)
          RG_CTRL:  rdata <= {30'b0, active, enable};
          RG_STAT:  rdata <= {29'b0, stat};
          RG_MASK:  rdata <= {29'b0, mask};
          RG_BURST: rdata <= 32'(burst);
          RG_BASE:  rdata <= base;
          default:  rdata <= '0;
        endcase
      end
    end
  end

  // R10: a full write-one-to-clear with no new event empties the status
  a_r10_w1c: assert property (@(posedge clk) disable iff (rst)
    (we && addr == RG_STAT && wdata[2:0] == 3'b111 && setv == 3'b0) |=> (stat == 3'b0));
endmodule

// File: rtl/txd_fifo.sv
module txd_fifo
  import txd_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  beat_word_t wdata,
  input  logic       rd,
  output beat_word_t rdata,
  output logic [CW-1:0] cnt,
  output logic       empty
);
  beat_word_t mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign empty = (cnt == '0);
  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(wr) - CW'(rd);
    end
  end

  // R2: fetched words are never lost to an overflow or a read of nothing
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr |-> (cnt < CW'(DEPTH) || rd));
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    rd |-> !empty);
endmodule

// File: rtl/txd_serial.sv
module txd_serial
  import txd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_empty,
  input  beat_word_t fifo_rdata,
  output logic       pop,
  output logic       busy,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_sop,
  output logic       tx_last,
  output logic       tx_crc
);
  logic        cur_v, c_first, c_last, c_crc;
  logic [31:0] sh;
  logic [2:0]  nb, idx;
  logic        fire, endb;

  assign fire = cur_v && tx_ready;
  assign endb = (idx == nb - 3'd1);
  assign pop  = !fifo_empty && (!cur_v || (fire && endb));
  assign busy = cur_v;

  assign tx_valid = cur_v;
  assign tx_data  = sh[7:0];
  assign tx_sop   = cur_v && c_first && idx == 3'd0;
  assign tx_crc   = cur_v && c_crc && idx == 3'd0;
  assign tx_last  = cur_v && c_last && endb;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v   <= 1'b0;
      sh      <= '0;
      nb      <= '0;
      idx     <= '0;
      c_first <= 1'b0;
      c_last  <= 1'b0;
      c_crc   <= 1'b0;
    end else if (pop) begin
      cur_v   <= 1'b1;
      sh      <= fifo_rdata.data;
      nb      <= fifo_rdata.nb;
      idx     <= '0;
      c_first <= fifo_rdata.first;
      c_last  <= fifo_rdata.last;
      c_crc   <= fifo_rdata.crc;
    end else if (fire) begin
      if (endb) cur_v <= 1'b0;
      else begin
        sh  <= sh >> 8;
        idx <= idx + 3'd1;
      end
    end
  end

  // R12: a stalled byte and its markers hold until accepted
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)
                                 && $stable(tx_last) && $stable(tx_crc)));
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int BURST_W = 6,
  localparam int CW     = $clog2(DEPTH) + 1,
  localparam int LIM_W  = BURST_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               kick,
  input  logic               base_wr,
  input  logic [31:0]        base_new,
  input  logic [31:0]        base,
  input  logic [BURST_W-1:0] burst,
  input  logic [CW-1:0]      fifo_cnt,
  input  logic               drained,
  output logic               mem_req,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata,
  output logic               push,
  output beat_word_t         push_word,
  output logic               active,
  output logic               bdone,
  output logic               pdone,
  output logic               nodesc
);
  eng_st_t     st;
  logic [31:0] ptr, ctl, baddr;
  logic [LEN_W-1:0] remain;
  logic        first_w, tail;
  logic [LIM_W-1:0] run, lim;

  assign lim  = (burst == '0) ? LIM_W'(2) : {burst, 1'b0};
  assign tail = (remain <= LEN_W'(4));
  assign push = (st == E_DATA) && mem_req && mem_ack;

  always_comb begin
    push_word.data  = mem_rdata;
    push_word.nb    = tail ? remain[2:0] : 3'd4;
    push_word.first = first_w && ctl[CTL_SOP];
    push_word.last  = tail && ctl[CTL_EOP];
    push_word.crc   = first_w && ctl[CTL_SOP] && ctl[CTL_CRC];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= E_IDLE;
      ptr       <= '0;
      ctl       <= '0;
      baddr     <= '0;
      remain    <= '0;
      first_w   <= 1'b0;
      run       <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      active    <= 1'b0;
      bdone     <= 1'b0;
      pdone     <= 1'b0;
      nodesc    <= 1'b0;
    end else begin
      bdone  <= 1'b0;
      pdone  <= 1'b0;
      nodesc <= 1'b0;
      case (st)
        E_IDLE: begin
          if (base_wr) ptr <= base_new;
          if (kick) begin
            active   <= 1'b1;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= ptr;
            st       <= E_CTL;
          end
        end
        E_CTL: if (mem_ack) begin
          ctl     <= mem_rdata;
          mem_req <= 1'b0;
          st      <= E_EVAL;
        end
        E_EVAL: begin
          if (!ctl[CTL_OWN]) begin
            nodesc <= 1'b1;
            active <= 1'b0;
            st     <= E_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= ptr + 32'd4;
            st       <= E_ADR;
          end
        end
        E_ADR: if (mem_ack) begin
          mem_req <= 1'b0;
          baddr   <= {mem_rdata[31:2], 2'b00};
          remain  <= ctl[LEN_LO +: LEN_W];
          first_w <= 1'b1;
          run     <= '0;
          st      <= (ctl[LEN_LO +: LEN_W] == '0) ? E_DRAIN : E_DATA;
        end
        E_DATA: begin
          if (!mem_req) begin
            if (fifo_cnt < CW'(DEPTH)) begin
              mem_req  <= 1'b1;
              mem_addr <= baddr;
            end
          end else if (mem_ack) begin
            baddr   <= baddr + 32'd4;
            first_w <= 1'b0;
            if (tail) begin
              remain  <= '0;
              mem_req <= 1'b0;
              run     <= '0;
              st      <= E_DRAIN;
            end else begin
              remain <= remain - LEN_W'(4);
              if ((run + 1'b1) >= lim || fifo_cnt >= CW'(DEPTH - 1)) begin
                mem_req <= 1'b0;
                run     <= '0;
              end else begin
                run      <= run + 1'b1;
                mem_addr <= baddr + 32'd4;
              end
            end
          end
        end
        E_DRAIN: if (drained) begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= ptr;
          mem_wdata <= ctl & ~(32'd1 << CTL_OWN);
          st        <= E_WB;
        end
        E_WB: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          bdone   <= 1'b1;
          pdone   <= ctl[CTL_EOP];
          ptr     <= ctl[CTL_WRAP] ? base : ptr + 32'd8;
          st      <= E_NEXT;
        end
        E_NEXT: begin
          if (enable) begin
            mem_req  <= 1'b1;
            mem_addr <= ptr;
            st       <= E_CTL;
          end else begin
            active <= 1'b0;
            st     <= E_IDLE;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // Checker: length of the current unbroken request run
  logic [LIM_W:0] acc_run;
  always_ff @(posedge clk) begin
    if (rst || !mem_req) acc_run <= '0;
    else if (mem_ack)    acc_run <= acc_run + 1'b1;
  end

  // R9: no run of back-to-back accesses exceeds the burst limit
  a_r9_burst_cap: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |-> (acc_run < {1'b0, lim}));
  // R2: an issued access keeps its address and direction until acknowledged
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R3: every write-back hands the descriptor back to software
  a_r3_wb_releases: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[CTL_OWN]);
  // R7: a parked channel issues no memory traffic
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |-> !mem_req);
endmodule

// File: rtl/txring_dma.sv
module txring_dma
  import txd_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int BURST_W    = 6,
  parameter int BURST_RST  = 8,
  localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_last,
  output logic        tx_crc,
  output logic        irq
);
  logic enable, kick, base_wr, active, bdone, pdone, nodesc;
  logic [31:0] base, base_new;
  logic [BURST_W-1:0] burst;
  logic push, pop, fifo_empty, ser_busy;
  logic [CW-1:0] fifo_cnt;
  beat_word_t push_word, head_word;

  txd_regs #(.BURST_W(BURST_W), .BURST_RST(BURST_RST)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .active(active),
    .set_bdone(bdone), .set_pdone(pdone), .set_nodesc(nodesc),
    .enable(enable), .kick(kick), .base_wr(base_wr), .base_new(base_new),
    .base(base), .burst(burst), .irq(irq)
  );

  txd_engine #(.DEPTH(FIFO_DEPTH), .BURST_W(BURST_W)) u_eng (
    .clk(clk), .rst(rst), .enable(enable), .kick(kick), .base_wr(base_wr),
    .base_new(base_new), .base(base), .burst(burst), .fifo_cnt(fifo_cnt),
    .drained(fifo_empty && !ser_busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .push(push), .push_word(push_word),
    .active(active), .bdone(bdone), .pdone(pdone), .nodesc(nodesc)
  );

  txd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr(push), .wdata(push_word), .rd(pop),
    .rdata(head_word), .cnt(fifo_cnt), .empty(fifo_empty)
  );

  txd_serial u_ser (
    .clk(clk), .rst(rst), .fifo_empty(fifo_empty), .fifo_rdata(head_word),
    .pop(pop), .busy(ser_busy), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_sop(tx_sop), .tx_last(tx_last), .tx_crc(tx_crc)
  );
endmodule

// File: tb/sim_txring_dma.sv
module sim_txring_dma;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b1, tx_sop, tx_last, tx_crc, irq;
  logic [7:0] tx_data;

  always #4 clk = ~clk;

  txring_dma u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop),
    .tx_last(tx_last), .tx_crc(tx_crc), .irq(irq)
  );

  int checks = 0, fails = 0;
  logic [31:0] mem [0:1023];
  logic [10:0] expq [$];
  int run = 0, maxrun = 0;
  bit idle_watch = 0;
  int idle_req = 0, idle_tx = 0;
  bit bp = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: one-cycle acknowledge, measures request runs
  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[11:2]];
        run++;
        if (run > maxrun) maxrun = run;
      end else mem_ack = 1'b0;
      if (!mem_req) run = 0;
      if (idle_watch && mem_req) idle_req++;
      if (idle_watch && tx_valid) idle_tx++;
    end
  end

  // Sink ready pattern
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    tx_ready = bp ? (cyc % 3 != 0) : 1'b1;
  end

  // Monitor: scoreboard pop and stall stability
  logic prev_stall = 1'b0;
  logic [10:0] prev_beat = '0;
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (prev_stall)
        chk(tx_valid && {tx_crc, tx_sop, tx_last, tx_data} == prev_beat, "R12 hold",
            32'({tx_valid, tx_crc, tx_sop, tx_last, tx_data}), 32'({1'b1, prev_beat}));
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0)
          chk(1'b0, "R2 unexpected byte", 32'({tx_crc, tx_sop, tx_last, tx_data}), 32'h0);
        else begin
          logic [10:0] e;
          e = expq.pop_front();
          chk({tx_crc, tx_sop, tx_last, tx_data} == e, "R2 R4 stream byte",
              32'({tx_crc, tx_sop, tx_last, tx_data}), 32'(e));
        end
      end
      prev_stall = tx_valid && !tx_ready;
      prev_beat  = {tx_crc, tx_sop, tx_last, tx_data};
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_re = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input int len, input bit own, input bit eop,
                                     input bit sop, input bit wrap, input bit crc);
    return (32'(len) << 16) | (32'(own) << 15) | (32'(eop) << 14) |
           (32'(sop) << 13) | (32'(wrap) << 12) | (32'(crc) << 8);
  endfunction

  // Driver: place a buffer and push the bytes the stream must show
  task automatic put_buf(input logic [31:0] ba, input int len, input logic [7:0] seed,
                         input bit sop, input bit eop, input bit crc, input bit expect_out);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = seed + 8'(i);
      mem[(ba >> 2) + 32'(i / 4)][8 * (i % 4) +: 8] = b;
      if (expect_out)
        expq.push_back({sop && crc && i == 0, sop && i == 0, eop && i == len - 1, b});
    end
  endtask

  task automatic put_desc(input logic [31:0] da, input logic [31:0] c, input logic [31:0] ba);
    mem[da >> 2] = c;
    mem[(da >> 2) + 1] = ba;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd0, d);
      if (!d[1] && expq.size() == 0) break;
    end
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !irq && !mem_req, "R1 outputs idle", 32'({tx_valid, irq, mem_req}), 32'h0);
    rd(3'd0, d); chk(d == 32'h0, "R1 control reset", d, 32'h0);
    rd(3'd3, d); chk(d == 32'd8, "R1 burst reset", d, 32'd8);

    wr(3'd4, 32'h0000_0107);
    rd(3'd4, d); chk(d == 32'h100, "R6 base alignment", d, 32'h100);

    // Single buffer packet with check-sequence request
    wr(3'd4, 32'h0);
    put_desc(32'h000, mk(10, 1, 1, 1, 0, 1), 32'h400);
    put_buf(32'h400, 10, 8'h10, 1, 1, 1, 1);
    wr(3'd0, 32'h1);
    wait_idle();
    chk(expq.size() == 0, "R2 all bytes sent", 32'(expq.size()), 32'h0);
    chk(mem[0] == mk(10, 0, 1, 1, 0, 1), "R3 write-back", mem[0], mk(10, 0, 1, 1, 0, 1));
    rd(3'd1, d); chk(d == 32'h7, "R10 R7 status bits", d, 32'h7);
    rd(3'd0, d); chk(d == 32'h1, "R7 active cleared", d, 32'h1);

    // Interrupt masking and clearing
    @(negedge clk); chk(!irq, "R11 masked off", 32'(irq), 32'h0);
    wr(3'd2, 32'h4);
    @(posedge clk); @(negedge clk);
    chk(irq, "R11 masked on", 32'(irq), 32'h1);
    wr(3'd1, 32'h7);
    rd(3'd1, d); chk(d == 32'h0, "R10 write-one-to-clear", d, 32'h0);
    @(negedge clk); chk(!irq, "R11 irq falls", 32'(irq), 32'h0);

    // Two-buffer packet
    wr(3'd4, 32'h40);
    put_desc(32'h040, mk(5, 1, 0, 1, 0, 1), 32'h440);
    put_desc(32'h048, mk(7, 1, 1, 0, 0, 1), 32'h480);
    put_buf(32'h440, 5, 8'h30, 1, 0, 1, 1);
    put_buf(32'h480, 7, 8'h50, 0, 1, 1, 1);
    wr(3'd0, 32'h1);
    wait_idle();
    chk(expq.size() == 0, "R4 multi-buffer packet", 32'(expq.size()), 32'h0);
    chk(mem[16'h48 >> 2][15] == 1'b0, "R3 second write-back", mem[16'h48 >> 2], 32'h0);
    rd(3'd1, d); chk(d == 32'h7, "R10 packet done", d, 32'h7);
    wr(3'd1, 32'h7);

    // Wrap back to base; the slot after the wrap must not be read
    wr(3'd4, 32'h80);
    put_desc(32'h080, mk(3, 1, 1, 1, 0, 0), 32'h500);
    put_desc(32'h088, mk(4, 1, 1, 1, 1, 0), 32'h540);
    put_desc(32'h090, mk(2, 1, 1, 1, 0, 0), 32'h580);
    put_buf(32'h500, 3, 8'h70, 1, 1, 0, 1);
    put_buf(32'h540, 4, 8'h80, 1, 1, 0, 1);
    put_buf(32'h580, 2, 8'hEE, 1, 1, 0, 0);
    wr(3'd0, 32'h1);
    wait_idle();
    chk(mem[32'h90 >> 2][15] == 1'b1, "R5 slot past wrap untouched", mem[32'h90 >> 2], 32'h1);

    // Parked channel stays quiet, then restarts at the same slot
    put_desc(32'h080, mk(6, 1, 1, 1, 0, 0), 32'h5C0);
    put_buf(32'h5C0, 6, 8'hA0, 1, 1, 0, 1);
    idle_req = 0; idle_tx = 0; idle_watch = 1;
    repeat (40) @(posedge clk);
    idle_watch = 0;
    chk(idle_req == 0 && idle_tx == 0, "R7 quiet while parked", 32'(idle_req + idle_tx), 32'h0);
    chk(expq.size() == 6, "R7 nothing sent while parked", 32'(expq.size()), 32'h6);
    wr(3'd0, 32'h1);
    wait_idle();
    chk(expq.size() == 0, "R5 R7 restart at base slot", 32'(expq.size()), 32'h0);
    chk(mem[32'h80 >> 2][15] == 1'b0, "R3 restart write-back", mem[32'h80 >> 2], 32'h0);

    // Burst limit under back-pressure
    wr(3'd1, 32'h7);
    wr(3'd3, 32'h2);
    wr(3'd4, 32'hC0);
    put_desc(32'h0C0, mk(40, 1, 1, 1, 0, 0), 32'h600);
    put_buf(32'h600, 40, 8'h01, 1, 1, 0, 1);
    bp = 1; maxrun = 0;
    wr(3'd0, 32'h1);
    wait_idle();
    bp = 0;
    chk(maxrun == 4, "R9 burst run", 32'(maxrun), 32'h4);
    chk(expq.size() == 0, "R12 stream under stalls", 32'(expq.size()), 32'h0);
    wr(3'd3, 32'h8);

    // Disable mid-buffer
    wr(3'd1, 32'h7);
    wr(3'd4, 32'h100);
    put_desc(32'h100, mk(20, 1, 1, 1, 0, 0), 32'h700);
    put_desc(32'h108, mk(4, 1, 1, 1, 0, 0), 32'h740);
    put_buf(32'h700, 20, 8'hC0, 1, 1, 0, 1);
    put_buf(32'h740, 4, 8'hF0, 1, 1, 0, 0);
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h0);
    wait_idle();
    chk(expq.size() == 0, "R8 current buffer finished", 32'(expq.size()), 32'h0);
    chk(mem[32'h108 >> 2][15] == 1'b1, "R8 next slot not taken", mem[32'h108 >> 2], 32'h1);
    rd(3'd1, d); chk(d == 32'h3, "R8 no empty-slot status", d, 32'h3);
    rd(3'd0, d); chk(d == 32'h0, "R8 stopped", d, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule